// File: doc/BRIEF.md
# Complex Sample Output Word Formatter

This block takes one complex result per cycle from a channel filter, as a pair of wide signed I and Q values qualified by a valid strobe, and converts both halves into the output word format chosen by a small set of control inputs. Three formats are offered: fixed point with a programmable left scale, a floating form with an 8-bit mantissa and a 4-bit exponent, and a floating form with a 12-bit mantissa and a 4-bit exponent.

In the floating forms the exponent is, by default, worked out for I and Q separately. A shared-exponent control makes both halves use one exponent taken from whichever of the two has the larger magnitude, so the pair reads as a single complex floating-point number. A force control replaces the computed exponent with the programmed scale. When that scale is too large for a given sample, the mantissa saturates instead of wrapping. The control inputs are sampled together with each input pair. Results appear a fixed two cycles later, one result for each accepted input.

Top module: `iq_float_fmt`

## Requirements
- R1: Each cycle with `in_vld` high produces exactly one cycle with `out_vld` high, two clock edges later. Back-to-back inputs give back-to-back outputs.
- R2: With `fmt_sel` = 00 (fixed point), each output word is bits [IN_W-1 : IN_W-16] of the input shifted left by `scale`. Both exponent outputs equal `scale`. If the shift would lose significant bits, the word saturates to 32767 for a non-negative input or to -32768 for a negative one.
- R3: The leading sign count of a value is the number of consecutive bits just below its MSB that equal the MSB. In a floating format with force off and shared exponent off, each lane's exponent is this count for its own input, limited to 15.
- R4: With `fmt_sel[1]` = 1 (codes 10 and 11), the mantissa is the top 12 bits of the input shifted left by the exponent, sign-extended to 16 bits.
- R5: With `fmt_sel` = 01, the mantissa is the top 8 bits of the input shifted left by the exponent, sign-extended to 16 bits.
- R6: In a floating format with `cmn_exp` = 1 and force off, both lanes use one exponent: the smaller of the two limited leading sign counts.
- R7: `cmn_exp` has no effect in fixed-point format.
- R8: With `force_exp` = 1 in a floating format, both exponents equal `scale`. The mantissa is the shifted value truncated to the mantissa width. If the leading sign count is below `scale`, the mantissa saturates to the largest positive or most negative code of that width. `cmn_exp` is then ignored.
- R9: While `out_vld` is low, every output word and exponent holds its last value.
- R10: During reset, `out_vld`, both words and both exponents are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input pair valid |
| in_i | input | IN_W | Signed I input |
| in_q | input | IN_W | Signed Q input |
| fmt_sel | input | 2 | 00 fixed, 01 8-bit mantissa, 1x 12-bit mantissa |
| cmn_exp | input | 1 | Shared exponent in floating formats |
| force_exp | input | 1 | Use `scale` as exponent in floating formats, with saturation |
| scale | input | 4 | Left scale for fixed or forced modes |
| out_vld | output | 1 | Output pair valid |
| out_i | output | 16 | I word or sign-extended I mantissa |
| out_q | output | 16 | Q word or sign-extended Q mantissa |
| exp_i | output | 4 | I exponent (the scale in fixed or forced modes) |
| exp_q | output | 4 | Q exponent |

## Verification
Hand-picked pairs come first. They include zero and all-ones inputs, which push the exponent to its limit. They also include the full-scale positive and negative values, which need no shift. One case has I and Q of very different magnitudes, which separates the independent exponents from the shared one. Others overflow the chosen scale in fixed and forced modes, to show saturation rather than wrap. A fixed-point pair with the shared control set shows that this control is ignored there, and the two codes for the 12-bit format are shown to behave alike. A back-to-back stream of arithmetic patterns then cycles through every format and control setting, to catch any mix-up of control between pipeline stages.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;
  localparam int EXP_W = 4;

  typedef struct packed {
    logic [1:0]       fmt;
    logic             cmn;
    logic             frc;
    logic [EXP_W-1:0] scale;
  } fmt_ctrl_t;
endpackage

// File: rtl/iq_fmt_lsc.sv
// Leading sign count, limited to the exponent range.
module iq_fmt_lsc #(
  parameter int W     = 24,
  parameter int EXP_W = 4
) (
  input  logic [W-1:0]     x,
  output logic [EXP_W-1:0] cnt
);
  localparam int CW  = $clog2(W) + 1;
  localparam int LIM = (1 << EXP_W) - 1;

  logic [CW-1:0] raw;
  logic          run;

  always_comb begin
    raw = '0;
    run = 1'b1;
    for (int b = W - 2; b >= 0; b--) begin
      if (run && (x[b] == x[W-1])) raw = raw + 1'b1;
      else                         run = 1'b0;
    end
  end

  assign cnt = (raw > CW'(LIM)) ? EXP_W'(LIM) : raw[EXP_W-1:0];
endmodule

// File: rtl/iq_fmt_shape.sv
// Shift by the chosen exponent, cut to the format width, saturate on loss.
module iq_fmt_shape #(
  parameter int IN_W   = 24,
  parameter int OUT_W  = 16,
  parameter int MAN_LO = 8,
  parameter int MAN_HI = 12,
  parameter int EXP_W  = 4
) (
  input  logic signed [IN_W-1:0]  x,
  input  logic        [EXP_W-1:0] lsc,
  input  logic        [EXP_W-1:0] sft,
  input  logic        [1:0]       fmt,
  output logic        [OUT_W-1:0] y
);
  localparam int NW = 3;

  logic signed [IN_W-1:0]  sh;
  logic                    ovf;
  logic        [OUT_W-1:0] cand [NW];

  assign sh  = x <<< sft;
  assign ovf = (lsc < sft);

  for (genvar g = 0; g < NW; g++) begin : g_width
    localparam int WG = (g == 0) ? OUT_W : ((g == 1) ? MAN_LO : MAN_HI);
    localparam logic [OUT_W-1:0] MXG = OUT_W'((2 ** (WG - 1)) - 1);
    localparam logic [OUT_W-1:0] MNG = ~MXG;
    logic signed [IN_W-1:0] cut;
    assign cut     = sh >>> (IN_W - WG);
    assign cand[g] = ovf ? (x[IN_W-1] ? MNG : MXG) : cut[OUT_W-1:0];
  end

  always_comb begin
    case (fmt)
      2'b00:   y = cand[0];
      2'b01:   y = cand[1];
      default: y = cand[2];
    endcase
  end
endmodule

// File: rtl/iq_fmt_rstsync.sv
module iq_fmt_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= 2'b00;
    else        sr <= {sr[0], 1'b1};
  end

  assign rst_sync_n = sr[1];
endmodule

// File: rtl/iq_float_fmt.sv
module iq_float_fmt #(
  parameter int IN_W   = 24,
  parameter int OUT_W  = 16,
  parameter int MAN_LO = 8,
  parameter int MAN_HI = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IN_W-1:0]   in_i,
  input  logic [IN_W-1:0]   in_q,
  input  logic [1:0]        fmt_sel,
  input  logic              cmn_exp,
  input  logic              force_exp,
  input  logic [3:0]        scale,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_i,
  output logic [OUT_W-1:0]  out_q,
  output logic [3:0]        exp_i,
  output logic [3:0]        exp_q
);
  import iq_fmt_pkg::*;

  logic rst_sync_n;

  iq_fmt_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // ---------------- stage 1: capture and count ----------------
  logic [EXP_W-1:0] lsc_i_c, lsc_q_c;

  iq_fmt_lsc #(.W(IN_W), .EXP_W(EXP_W)) u_lsc_i (.x(in_i), .cnt(lsc_i_c));
  iq_fmt_lsc #(.W(IN_W), .EXP_W(EXP_W)) u_lsc_q (.x(in_q), .cnt(lsc_q_c));

  logic             v1, v1_d;
  logic [IN_W-1:0]  x1_i, x1_i_d, x1_q, x1_q_d;
  logic [EXP_W-1:0] lsc1_i, lsc1_i_d, lsc1_q, lsc1_q_d;
  fmt_ctrl_t        c1, c1_d;

  always_comb begin
    v1_d     = in_vld;
    x1_i_d   = x1_i;
    x1_q_d   = x1_q;
    lsc1_i_d = lsc1_i;
    lsc1_q_d = lsc1_q;
    c1_d     = c1;
    if (in_vld) begin
      x1_i_d   = in_i;
      x1_q_d   = in_q;
      lsc1_i_d = lsc_i_c;
      lsc1_q_d = lsc_q_c;
      c1_d     = '{fmt: fmt_sel, cmn: cmn_exp, frc: force_exp, scale: scale};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1     <= 1'b0;
      x1_i   <= '0;
      x1_q   <= '0;
      lsc1_i <= '0;
      lsc1_q <= '0;
      c1     <= '0;
    end else begin
      v1     <= v1_d;
      x1_i   <= x1_i_d;
      x1_q   <= x1_q_d;
      lsc1_i <= lsc1_i_d;
      lsc1_q <= lsc1_q_d;
      c1     <= c1_d;
    end
  end

  // ---------------- stage 2: exponent choice and shaping ----------------
  logic             flt, use_scale;
  logic [EXP_W-1:0] emin, sft_i, sft_q;
  logic [OUT_W-1:0] y_i, y_q;

  always_comb begin
    flt       = |c1.fmt;
    use_scale = !flt || c1.frc;
    emin      = (lsc1_i < lsc1_q) ? lsc1_i : lsc1_q;
    if (use_scale) begin
      sft_i = c1.scale;
      sft_q = c1.scale;
    end else if (c1.cmn) begin
      sft_i = emin;
      sft_q = emin;
    end else begin
      sft_i = lsc1_i;
      sft_q = lsc1_q;
    end
  end

  iq_fmt_shape #(.IN_W(IN_W), .OUT_W(OUT_W), .MAN_LO(MAN_LO), .MAN_HI(MAN_HI),
                 .EXP_W(EXP_W)) u_shape_i (
    .x(x1_i), .lsc(lsc1_i), .sft(sft_i), .fmt(c1.fmt), .y(y_i));

  iq_fmt_shape #(.IN_W(IN_W), .OUT_W(OUT_W), .MAN_LO(MAN_LO), .MAN_HI(MAN_HI),
                 .EXP_W(EXP_W)) u_shape_q (
    .x(x1_q), .lsc(lsc1_q), .sft(sft_q), .fmt(c1.fmt), .y(y_q));

  logic             out_vld_d;
  logic [OUT_W-1:0] out_i_d, out_q_d;
  logic [EXP_W-1:0] exp_i_d, exp_q_d;

  always_comb begin
    out_vld_d = v1;
    out_i_d   = out_i;
    out_q_d   = out_q;
    exp_i_d   = exp_i;
    exp_q_d   = exp_q;
    if (v1) begin
      out_i_d = y_i;
      out_q_d = y_q;
      exp_i_d = sft_i;
      exp_q_d = sft_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_vld <= 1'b0;
      out_i   <= '0;
      out_q   <= '0;
      exp_i   <= '0;
      exp_q   <= '0;
    end else begin
      out_vld <= out_vld_d;
      out_i   <= out_i_d;
      out_q   <= out_q_d;
      exp_i   <= exp_i_d;
      exp_q   <= exp_q_d;
    end
  end
endmodule

// File: rtl/iq_float_fmt_chk.sv
module iq_float_fmt_chk #(
  parameter int OUT_W  = 16,
  parameter int MAN_LO = 8,
  parameter int MAN_HI = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_i,
  input logic [OUT_W-1:0] out_q,
  input logic [3:0]       exp_i,
  input logic [3:0]       exp_q,
  input logic [1:0]       c_fmt,
  input logic             c_cmn,
  input logic             c_frc,
  input logic [3:0]       c_scale
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age <= 2'd0;
    else if (age != 2'd3)   age <= age + 2'd1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_vld == $past(in_vld, 2)));

  p_fix_exp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_vld && $past(c_fmt) == 2'b00)
      |-> (exp_i == $past(c_scale) && exp_q == $past(c_scale)));

  p_norm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_vld && $past(c_fmt[1]) && !$past(c_frc) && !$past(c_cmn)
     && exp_i != 4'd15)
      |-> (out_i[MAN_HI-1] != out_i[MAN_HI-2]));

  p_man8_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_vld && $past(c_fmt) == 2'b01)
      |-> (out_i[OUT_W-1:MAN_LO-1] == '0 || out_i[OUT_W-1:MAN_LO-1] == '1));

  p_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_vld && $past(c_fmt) != 2'b00 && $past(c_cmn))
      |-> (exp_i == exp_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !out_vld)
      |-> ($stable(out_i) && $stable(out_q) && $stable(exp_i) && $stable(exp_q)));
endmodule

bind iq_float_fmt iq_float_fmt_chk #(.OUT_W(OUT_W), .MAN_LO(MAN_LO), .MAN_HI(MAN_HI)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_vld(in_vld), .out_vld(out_vld),
  .out_i(out_i), .out_q(out_q), .exp_i(exp_i), .exp_q(exp_q),
  .c_fmt(c1.fmt), .c_cmn(c1.cmn), .c_frc(c1.frc), .c_scale(c1.scale));

// File: tb/iq_float_fmt_test.sv
module iq_float_fmt_test;
  localparam int IN_W  = 24;
  localparam int OUT_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_vld;
  logic [IN_W-1:0]   in_i, in_q;
  logic [1:0]        fmt_sel;
  logic              cmn_exp, force_exp;
  logic [3:0]        scale;
  logic              out_vld;
  logic [OUT_W-1:0]  out_i, out_q;
  logic [3:0]        exp_i, exp_q;

  iq_float_fmt uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .fmt_sel(fmt_sel), .cmn_exp(cmn_exp), .force_exp(force_exp), .scale(scale),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q), .exp_i(exp_i), .exp_q(exp_q));

  always #10 clk = ~clk;

  typedef struct {
    logic [OUT_W-1:0] wi, wq;
    logic [3:0]       ei, eq;
    int               cyc;
    string            tag;
  } item_t;

  item_t sb[$];
  int    n_chk = 0, n_fail = 0, cyc = 0;
  logic [OUT_W-1:0] last_i, last_q;
  logic [3:0]       last_ei, last_eq;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lsc_f(logic [IN_W-1:0] x);
    int k = 0;
    bit run = 1'b1;
    for (int b = IN_W - 2; b >= 0; b--) begin
      if (run && x[b] == x[IN_W-1]) k++;
      else run = 1'b0;
    end
    return k;
  endfunction

  function automatic logic [OUT_W-1:0] word_f(logic [IN_W-1:0] x, int s, int w, int l);
    logic signed [IN_W-1:0] sh;
    logic signed [IN_W-1:0] cut;
    if (l < s) return x[IN_W-1] ? OUT_W'(-(2 ** (w - 1))) : OUT_W'((2 ** (w - 1)) - 1);
    sh  = $signed(x) <<< s;
    cut = sh >>> (IN_W - w);
    return cut[OUT_W-1:0];
  endfunction

  task automatic send(input logic [IN_W-1:0] i, input logic [IN_W-1:0] q,
                      input logic [1:0] f, input logic c, input logic fr,
                      input logic [3:0] sc, input string tag);
    item_t it;
    int li, lq, ei, eq, w, si, sq;
    @(negedge clk);
    in_vld = 1'b1; in_i = i; in_q = q; fmt_sel = f;
    cmn_exp = c; force_exp = fr; scale = sc;
    li = lsc_f(i); lq = lsc_f(q);
    ei = (li > 15) ? 15 : li;
    eq = (lq > 15) ? 15 : lq;
    w  = f[1] ? 12 : (f[0] ? 8 : 16);
    if (f == 2'b00 || fr) begin si = sc; sq = sc; end
    else if (c) begin si = (ei < eq) ? ei : eq; sq = si; end
    else begin si = ei; sq = eq; end
    it.wi = word_f(i, si, w, li);
    it.wq = word_f(q, sq, w, lq);
    it.ei = 4'(si); it.eq = 4'(sq);
    it.cyc = cyc; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_vld = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R1: output valid with nothing expected (act 1, exp 0)");
      end else begin
        item_t e;
        e = sb.pop_front();
        if (cyc - e.cyc != 2) begin
          n_fail++;
          $display("FAIL R1: latency act %0d exp 2", cyc - e.cyc);
        end
        if (out_i !== e.wi || out_q !== e.wq || exp_i !== e.ei || exp_q !== e.eq) begin
          n_fail++;
          $display("FAIL %s: act i=%h q=%h ei=%0d eq=%0d exp i=%h q=%h ei=%0d eq=%0d",
                   e.tag, out_i, out_q, exp_i, exp_q, e.wi, e.wq, e.ei, e.eq);
        end
      end
      last_i = out_i; last_q = out_q; last_ei = exp_i; last_eq = exp_q;
    end
  end

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act running exp done");
    report();
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_i = '0; in_q = '0;
    fmt_sel = 2'b00; cmn_exp = 1'b0; force_exp = 1'b0; scale = 4'd0;
    repeat (3) @(negedge clk);
    n_chk++; // R10 reset state
    if (out_vld !== 1'b0 || out_i !== '0 || out_q !== '0 || exp_i !== '0 || exp_q !== '0) begin
      n_fail++;
      $display("FAIL R10: act vld=%b i=%h q=%h exp vld=0 i=0 q=0", out_vld, out_i, out_q);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(24'h123456, 24'hFFFC18, 2'b00, 1'b0, 1'b0, 4'd0,  "R2");
    send(24'h001234, 24'hFFF000, 2'b00, 1'b1, 1'b0, 4'd4,  "R7");
    send(24'h400000, 24'hA00000, 2'b00, 1'b0, 1'b0, 4'd2,  "R2");
    send(24'h000123, 24'hFFFFB3, 2'b10, 1'b0, 1'b0, 4'd0,  "R4");
    send(24'h7FFFFF, 24'h800000, 2'b11, 1'b0, 1'b0, 4'd9,  "R4");
    send(24'h000000, 24'hFFFFFF, 2'b10, 1'b0, 1'b0, 4'd0,  "R3");
    send(24'h003456, 24'hFF8001, 2'b01, 1'b0, 1'b0, 4'd0,  "R5");
    send(24'h000F00, 24'h000010, 2'b10, 1'b1, 1'b0, 4'd0,  "R6");
    send(24'hFFFF00, 24'h020000, 2'b01, 1'b1, 1'b0, 4'd0,  "R6");
    send(24'h001000, 24'h000010, 2'b10, 1'b0, 1'b1, 4'd12, "R8");
    send(24'hFFF800, 24'h000100, 2'b01, 1'b1, 1'b1, 4'd8,  "R8");
    idle(6);

    n_chk++; // R9 outputs hold while idle
    if (out_vld !== 1'b0 || out_i !== last_i || out_q !== last_q ||
        exp_i !== last_ei || exp_q !== last_eq) begin
      n_fail++;
      $display("FAIL R9: act i=%h q=%h exp i=%h q=%h", out_i, out_q, last_i, last_q);
    end

    for (int k = 0; k < 48; k++) begin
      send(IN_W'(k * k * 40961 + k * 257), IN_W'(32'hFFFFFF ^ (k * 3001 << (k % 11))),
           2'(k % 4), k[2], k[3] & k[0], 4'(k * 5), "R3");
    end
    idle(6);

    n_chk++; // R1 every input matched by an output
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: pending act %0d exp 0", sb.size());
    end
    report();
  end
endmodule